// File: doc/BRIEF.md
# PWM Output Fault Guard

This block stands between a PWM timer and the output pins it drives. It holds the output-override enable vector and the pin direction vector for a group of PWM pins. When any enabled event input pulses, it protects those pins. A mask register selects which event channels count as fault sources. A sticky fault flag records that a fault has happened. An encoded action field selects the response. One response switches the output override off by clearing every override-enable bit. The other tri-states the pins that belong to enabled dead-time channels by clearing their direction bits. Two codes take no action.

Software uses a small register port to set the action, the mask, the dead-time channel enables and the two output vectors. It reads the fault flag from a status register and clears the flag by writing a one to it. Each dead-time channel owns two pins: the low side on pin 2c and the high side on pin 2c+1. Event pulses are sampled on the rising clock edge. The flag and the outputs change at that same edge, so they are visible in the following cycle.

Top module: `pwm_fault_guard`

## Requirements
- R1: When an event pulse arrives on a channel whose bit is set in the event mask (address 1), the fault flag is set at that clock edge. Event pulses on channels whose mask bit is clear change neither the flag nor any output.
- R2: The fault flag is sticky. Writing address 5 with bit 2 at one clears it. Writing address 5 with bit 2 at zero leaves it unchanged.
- R3: When a masked event and a clearing write to the flag fall in the same cycle, the event wins and the flag stays set.
- R4: With action code 01 (address 0, bits 1:0), a fault clears all override-enable bits at the edge that samples the event, even if software writes the override register in that cycle. The direction vector is left unchanged.
- R5: With action code 11, a fault clears both direction bits (pins 2c and 2c+1) of every dead-time channel c whose enable bit in address 2 is set. All other direction bits and the override vector are left unchanged.
- R6: With action code 00 (protection disabled) or 10 (reserved), a fault sets the flag but leaves the override and direction vectors unchanged.
- R7: Reading the status register (address 5) returns the fault flag in bit 2. All other bits read as zero.
- R8: Addresses 0 to 4 (action, event mask, channel enable, override enable, direction) read back what was written. Reset clears every register and the flag to zero. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| evt | input | NEV (8) | Event pulses, one cycle each |
| oven_o | output | NPIN (8) | Output-override enable vector |
| dir_o | output | NPIN (8) | Pin direction vector, 1 = driven |

## Verification
On every cycle, the assertions check the flag setting and its stickiness (R1, R2) and the per-action effect on the override and direction vectors (R4, R5, R6). They also check that the status register's spare bits stay zero (R7). Some behaviour is only exercised by the bench scenarios: the readback of each register, the rejection of unmasked events, a zero written to the flag, and a same-cycle set and clear. In those scenarios a behavioural model is compared with every output on every clock.

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int NCH = 4,
  parameter int NEV = 8,
  parameter int DW  = 8,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic [NEV-1:0] evt,
  output logic [2*NCH-1:0] oven_o,
  output logic [2*NCH-1:0] dir_o
);
  localparam int NPIN = 2 * NCH;
  localparam int FLAG_BIT = 2;
  localparam logic [AW-1:0] A_ACT  = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_CHEN = AW'(2);
  localparam logic [AW-1:0] A_OVEN = AW'(3);
  localparam logic [AW-1:0] A_DIR  = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);

  logic [1:0]      act;
  logic [NEV-1:0]  mask;
  logic [NCH-1:0]  chen;
  logic            flag;
  logic [NPIN-1:0] pmask;

  wire hit    = |(evt & mask);
  wire clr_wr = wr_en && addr == A_STAT && wdata[FLAG_BIT];

  for (genvar c = 0; c < NCH; c++) begin : g_pair
    assign pmask[2*c]   = chen[c];
    assign pmask[2*c+1] = chen[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= '0;
      mask   <= '0;
      chen   <= '0;
      oven_o <= '0;
      dir_o  <= '0;
      flag   <= 1'b0;
    end else begin
      if (wr_en && addr == A_ACT)  act  <= wdata[1:0];
      if (wr_en && addr == A_MASK) mask <= wdata[NEV-1:0];
      if (wr_en && addr == A_CHEN) chen <= wdata[NCH-1:0];

      if (hit && act == 2'b01)
        oven_o <= '0;
      else if (wr_en && addr == A_OVEN)
        oven_o <= wdata[NPIN-1:0];

      if (hit && act == 2'b11)
        dir_o <= (wr_en && addr == A_DIR ? wdata[NPIN-1:0] : dir_o) & ~pmask;
      else if (wr_en && addr == A_DIR)
        dir_o <= wdata[NPIN-1:0];

      if (hit)         flag <= 1'b1;
      else if (clr_wr) flag <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr)
      A_ACT:   rdata = DW'(act);
      A_MASK:  rdata = DW'(mask);
      A_CHEN:  rdata = DW'(chen);
      A_OVEN:  rdata = DW'(oven_o);
      A_DIR:   rdata = DW'(dir_o);
      A_STAT:  rdata = DW'({flag, 2'b00});
      default: rdata = '0;
    endcase
  end

  assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr) |=> flag);
  assert_oven_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == 2'b01) |=> oven_o == '0);
  assert_dir_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == 2'b11) |=> (dir_o & $past(pmask)) == '0);
  assert_no_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !act[0] && !wr_en) |=> $stable(oven_o) && $stable(dir_o));
  assert_status_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr == A_STAT |-> (rdata & ~DW'(1 << FLAG_BIT)) == '0);
endmodule

// File: tb/pwm_fault_guard_test.sv
module pwm_fault_guard_test;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, evt = 0;
  logic [7:0] rdata, oven_o, dir_o;
  int checks = 0, failures = 0;
  string tag = "R8";
  int m_act, m_mask, m_chen, m_oven, m_dir, m_flag;

  always #10 clk = ~clk;

  pwm_fault_guard uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt(evt), .oven_o(oven_o), .dir_o(dir_o));

  function automatic int pins_of(int ch);
    int r = 0;
    for (int c = 0; c < 4; c++) if (ch[c]) r |= 3 << (2 * c);
    return r;
  endfunction

  function automatic int exp_rd(int a);
    case (a)
      0: return m_act;  1: return m_mask; 2: return m_chen;
      3: return m_oven; 4: return m_dir;  5: return m_flag << 2;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_mask = 0; m_chen = 0; m_oven = 0; m_dir = 0; m_flag = 0;
    end else begin
      int o_act, o_chen;
      bit hit;
      o_act = m_act; o_chen = m_chen;
      hit = (int'(evt) & m_mask) != 0;
      if (wr_en) case (int'(addr))
        0: m_act = wdata & 3;
        1: m_mask = wdata;
        2: m_chen = wdata & 15;
        3: m_oven = wdata;
        4: m_dir = wdata;
        5: if (wdata[2]) m_flag = 0;
        default: ;
      endcase
      if (hit) begin
        m_flag = 1;
        if (o_act == 1) m_oven = 0;
        if (o_act == 3) m_dir = m_dir & ~pins_of(o_chen);
      end
    end
  end

  task automatic chk(string what, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act_v, exp_v);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("oven", oven_o, m_oven);
    chk("dir", dir_o, m_dir);
    chk("rdata", rdata, exp_rd(addr));
  end

  task automatic wr(int a, int d, int e = 0);
    @(negedge clk); wr_en = 1; addr = 3'(a); wdata = 8'(d); evt = 8'(e);
    @(negedge clk); wr_en = 0; evt = 0;
  endtask
  task automatic ev(int e);
    @(negedge clk); evt = 8'(e);
    @(negedge clk); evt = 0;
  endtask
  task automatic rd(int a, int exp_v, string t);
    @(negedge clk); addr = 3'(a); #1;
    tag = t; chk("readback", rdata, exp_v);
  endtask

  initial begin
    #5000000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    tag = "R8"; chk("reset oven", oven_o, 0); chk("reset dir", dir_o, 0);
    rst_n = 1;
    for (int a = 0; a < 8; a++) rd(a, 0, "R8");
    wr(1, 8'h0C); wr(2, 8'h05); wr(3, 8'hFF); wr(4, 8'hFF);
    rd(1, 8'h0C, "R8"); rd(2, 8'h05, "R8"); rd(3, 8'hFF, "R8"); rd(4, 8'hFF, "R8");
    tag = "R1"; ev(8'hF3); rd(5, 0, "R1"); rd(3, 8'hFF, "R1");
    tag = "R6"; ev(8'h04); rd(5, 4, "R6"); rd(3, 8'hFF, "R6"); rd(4, 8'hFF, "R6");
    tag = "R2"; wr(5, 8'hFB); rd(5, 4, "R2"); wr(5, 8'h04); rd(5, 0, "R2");
    wr(0, 2); tag = "R6"; ev(8'h08); rd(3, 8'hFF, "R6"); rd(4, 8'hFF, "R6"); wr(5, 4);
    wr(0, 1); tag = "R4"; ev(8'h08); rd(3, 0, "R4"); rd(4, 8'hFF, "R4"); rd(5, 4, "R4");
    wr(5, 4); tag = "R4"; wr(3, 8'hA5, 8'h04); rd(3, 0, "R4");
    wr(3, 8'hFF); wr(0, 3);
    tag = "R5"; ev(8'h04); rd(4, 8'hCC, "R5"); rd(3, 8'hFF, "R5");
    wr(4, 8'hFF); wr(2, 8'h0A); wr(5, 4); ev(8'h08); rd(4, 8'h33, "R5");
    tag = "R3"; wr(5, 8'h04, 8'h04); rd(5, 4, "R3");
    tag = "R7"; wr(5, 8'hFF); rd(5, 0, "R7"); ev(8'h0C); rd(5, 4, "R7");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule